// File: doc/BRIEF.md
# Cache Line and Range Maintenance Engine

This block runs maintenance on a physically indexed, physically tagged cache with 32-byte lines. A requester sends it commands one at a time. Single-line commands clean, invalidate, or clean-and-invalidate the line that holds a given address. Range commands take two ordered writes: a start write records the first address, and the matching end write starts a walk over every line whose base address lies between the two addresses, counting both ends.

For each line the engine presents the line address and the operation on a tag-array maintenance port, using a valid/ready handshake. It issues at most one line per cycle. The busy output stays high for the whole walk, which stalls the requester. Only the start address goes through translation, so both ends of a range must sit in the same 4 KiB page. A range that crosses a page boundary is refused and an error flag is raised. There are two range flavours, clean and invalidate, and each keeps its own pending start address.

Top module: `line_maint_engine`

## Requirements
- R1: Every tag-port request carries a line base address with bits [4:0] zero. A single-line command targets the line that contains `cmd_addr`.
- R2: Command codes 0, 1 and 2 are single-line clean, invalidate, and clean-plus-invalidate. Each produces exactly one request, with `tag_req_op` set to 1, 2 and 3 respectively.
- R3: Code 3 writes the pending clean-range start and code 5 writes the pending invalidate-range start. Neither raises busy or issues a request. Code 4 (clean end) and code 6 (invalidate end) launch the walk.
- R4: A range walk issues the lines from line(start) up to and including line(end), in ascending order, one per handshake. A clean range uses op 1 and an invalidate range uses op 2.
- R5: Busy rises in the cycle after an accepted launching command and stays high through the cycle of the final handshake. It is low in the following cycle, so with the port always ready an N-line walk is busy for exactly N cycles.
- R6: An end write whose address bits [31:12] differ from those of its pending start issues no request and leaves busy low. It sets `err` in the next cycle. `err` clears when the next command with code 0 to 6 is accepted.
- R7: An end write whose line lies below the start line in the same page issues no request and holds busy for exactly one cycle.
- R8: A second start write replaces the earlier one for that flavour. The clean and invalidate start registers are independent of each other.
- R9: A request that is not accepted keeps `tag_req_valid`, `tag_req_addr` and `tag_req_op` unchanged until it is accepted.
- R10: Commands presented while busy is high are ignored, and code 7 is ignored at all times.
- R11: After reset, busy, `tag_req_valid` and `err` are low and both pending start registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; accepted when busy is low |
| cmd_code | input | 3 | Command code (see R2, R3, R10) |
| cmd_addr | input | ADDR_W | Command address |
| busy | output | 1 | Requester stall, high during a walk |
| err | output | 1 | Page-crossing range refused |
| tag_req_valid | output | 1 | Line request to the tag array |
| tag_req_op | output | 2 | 1 clean, 2 invalidate, 3 clean+invalidate |
| tag_req_addr | output | ADDR_W | Line base address |
| tag_req_ready | input | 1 | Tag array accepts the request |

## Verification
The assertions assume that the requester keeps `cmd_valid` low while it waits on busy, except on purpose, and that `tag_req_ready` may drop at any cycle. The address-step property also relies on there being at least one idle cycle between two walks, which the busy interlock guarantees. The stimulus sets the ready line at random on every cycle. It draws starts and ends inside a few pages, biased so that forward, reversed and page-crossing ranges all occur. It raises a command in the middle of a walk only in the directed case that checks it is ignored.

// File: rtl/lme_pkg.sv
package lme_pkg;

    localparam int LINE_LG = 5;
    localparam int PAGE_LG = 12;
    localparam int N_RANGE = 2;

    typedef enum logic [2:0] {
        CMD_LINE_CLEAN  = 3'd0,
        CMD_LINE_INV    = 3'd1,
        CMD_LINE_CINV   = 3'd2,
        CMD_CLEAN_START = 3'd3,
        CMD_CLEAN_END   = 3'd4,
        CMD_INV_START   = 3'd5,
        CMD_INV_END     = 3'd6,
        CMD_NOP         = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_INV   = 2'd2,
        OP_CINV  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_DRAIN = 2'd2
    } walk_st_e;

    typedef struct packed {
        logic known;
        logic is_line;
        logic is_start;
        logic is_end;
        logic rng;
        op_e  op;
    } dec_t;

    function automatic dec_t lme_decode(logic [2:0] code);
        dec_t d;
        d = '{known: 1'b1, is_line: 1'b0, is_start: 1'b0, is_end: 1'b0,
              rng: 1'b0, op: OP_NONE};
        case (cmd_e'(code))
            CMD_LINE_CLEAN:  begin d.is_line = 1'b1; d.op = OP_CLEAN; end
            CMD_LINE_INV:    begin d.is_line = 1'b1; d.op = OP_INV;   end
            CMD_LINE_CINV:   begin d.is_line = 1'b1; d.op = OP_CINV;  end
            CMD_CLEAN_START: begin d.is_start = 1'b1; d.rng = 1'b0; end
            CMD_CLEAN_END:   begin d.is_end = 1'b1; d.rng = 1'b0; d.op = OP_CLEAN; end
            CMD_INV_START:   begin d.is_start = 1'b1; d.rng = 1'b1; end
            CMD_INV_END:     begin d.is_end = 1'b1; d.rng = 1'b1; d.op = OP_INV; end
            default:         d.known = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lme_start_regs.sv
module lme_start_regs #(
    parameter int LW    = 27,
    parameter int N_RNG = 2,
    localparam int IW   = (N_RNG > 1) ? $clog2(N_RNG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [LW-1:0] wr_line,
    input  logic [IW-1:0] rd_idx,
    output logic [LW-1:0] rd_line
);
    logic [LW-1:0] held [N_RNG];

    for (genvar g = 0; g < N_RNG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                held[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                held[g] <= wr_line;
        end
    end

    assign rd_line = held[rd_idx];
endmodule

// File: rtl/lme_range_check.sv
module lme_range_check #(
    parameter int LW    = 27,
    parameter int PG_SH = 7,
    localparam int PW   = LW - PG_SH
) (
    input  logic [LW-1:0] first_line,
    input  logic [LW-1:0] last_line,
    output logic          same_page,
    output logic          reversed
);
    logic [PW-1:0] pg_first, pg_last;

    always_comb begin
        pg_first  = first_line[LW-1:PG_SH];
        pg_last   = last_line[LW-1:PG_SH];
        same_page = (pg_first == pg_last);
        reversed  = (last_line < first_line);
    end
endmodule

// File: rtl/lme_walker.sv
module lme_walker
    import lme_pkg::*;
#(
    parameter int LW = 27
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          launch_empty,
    input  logic [LW-1:0] launch_first,
    input  logic [LW-1:0] launch_last,
    input  op_e           launch_op,
    input  logic          port_ready,
    output logic          busy,
    output logic          req_valid,
    output logic [LW-1:0] req_line,
    output op_e           req_op
);
    walk_st_e      st;
    logic [LW-1:0] cur, stop;
    op_e           op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            stop <= '0;
            op_q <= OP_NONE;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (launch) begin
                        cur  <= launch_first;
                        stop <= launch_last;
                        op_q <= launch_op;
                        st   <= launch_empty ? ST_DRAIN : ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (port_ready) begin
                        if (cur == stop)
                            st <= ST_IDLE;
                        else
                            cur <= cur + LW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign req_valid = (st == ST_WALK);
    assign req_line  = cur;
    assign req_op    = op_q;
endmodule

// File: rtl/line_maint_engine.sv
module line_maint_engine
    import lme_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int LW    = ADDR_W - LINE_LG,
    localparam int PG_SH = PAGE_LG - LINE_LG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              err,
    output logic              tag_req_valid,
    output logic [1:0]        tag_req_op,
    output logic [ADDR_W-1:0] tag_req_addr,
    input  logic              tag_req_ready
);
    dec_t          dec;
    logic          accept;
    logic [LW-1:0] cmd_line, start_line, req_line;
    logic          same_page, reversed;
    logic          launch, launch_empty;
    logic [LW-1:0] launch_first;
    op_e           req_op;

    assign dec      = lme_decode(cmd_code);
    assign accept   = cmd_valid && !busy;
    assign cmd_line = cmd_addr[ADDR_W-1:LINE_LG];

    lme_start_regs #(.LW(LW), .N_RNG(N_RANGE)) u_start (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && dec.is_start),
        .wr_idx  (dec.rng),
        .wr_line (cmd_line),
        .rd_idx  (dec.rng),
        .rd_line (start_line)
    );

    lme_range_check #(.LW(LW), .PG_SH(PG_SH)) u_chk_rng (
        .first_line (start_line),
        .last_line  (cmd_line),
        .same_page  (same_page),
        .reversed   (reversed)
    );

    always_comb begin
        launch       = accept && (dec.is_line || (dec.is_end && same_page));
        launch_empty = dec.is_end && reversed;
        launch_first = dec.is_line ? cmd_line : start_line;
    end

    lme_walker #(.LW(LW)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .launch_empty (launch_empty),
        .launch_first (launch_first),
        .launch_last  (cmd_line),
        .launch_op    (dec.op),
        .port_ready   (tag_req_ready),
        .busy         (busy),
        .req_valid    (tag_req_valid),
        .req_line     (req_line),
        .req_op       (req_op)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (accept && dec.known)
            err <= dec.is_end && !same_page;
    end

    assign tag_req_addr = {req_line, {LINE_LG{1'b0}}};
    assign tag_req_op   = req_op;
endmodule

// File: rtl/lme_checker.sv
module lme_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              busy,
    input logic              err,
    input logic              tag_req_valid,
    input logic [1:0]        tag_req_op,
    input logic [ADDR_W-1:0] tag_req_addr,
    input logic              tag_req_ready
);
    // R2: an accepted single-line command raises a request for its own line
    a_r2_line_launch: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && (cmd_code <= 3'd2)) |=>
            (busy && tag_req_valid &&
             tag_req_addr[ADDR_W-1:5] == $past(cmd_addr[ADDR_W-1:5])));

    // R4: consecutive requests within one walk step by one line
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (tag_req_valid && tag_req_ready) ##1 tag_req_valid |->
            (tag_req_addr == $past(tag_req_addr) + ADDR_W'(32)));

    // R5: busy falls only after a handshake or an empty drain cycle
    a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(!tag_req_valid || tag_req_ready));

    // R6: a refused range never raises busy or a request
    a_r6_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (!busy && !tag_req_valid));

    // R9: a stalled request holds its contents
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (tag_req_valid && !tag_req_ready) |=>
            (tag_req_valid && $stable(tag_req_addr) && $stable(tag_req_op)));

    // R2: a request never carries the null operation
    a_r2_op_legal: assert property (@(posedge clk) disable iff (rst)
        tag_req_valid |-> (tag_req_op != 2'd0));
endmodule

bind line_maint_engine lme_checker #(.ADDR_W(ADDR_W)) u_lme_checker (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .cmd_addr      (cmd_addr),
    .busy          (busy),
    .err           (err),
    .tag_req_valid (tag_req_valid),
    .tag_req_op    (tag_req_op),
    .tag_req_addr  (tag_req_addr),
    .tag_req_ready (tag_req_ready)
);

// File: tb/line_maint_engine_tb.sv
module line_maint_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd7;
    logic [31:0] cmd_addr = '0;
    logic        busy, err, tag_req_valid, tag_req_ready;
    logic [1:0]  tag_req_op;
    logic [31:0] tag_req_addr;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [31:0] ms [2];
    bit          err_m = 0;
    logic [31:0] hs_addr [$];
    logic [1:0]  hs_op [$];

    always #5 clk = ~clk;

    line_maint_engine u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .busy(busy), .err(err),
        .tag_req_valid(tag_req_valid), .tag_req_op(tag_req_op),
        .tag_req_addr(tag_req_addr), .tag_req_ready(tag_req_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] code, input logic [31:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'd7;
    endtask

    task automatic observe(input bit inject, input bit full, output int nb);
        hs_addr.delete(); hs_op.delete(); nb = 0;
        forever begin
            tag_req_ready = full ? 1'b1 : (($urandom % 4) != 0);
            if (inject && nb == 1) begin
                cmd_valid = 1'b1; cmd_code = 3'd1; cmd_addr = 32'h0000_0F00;
            end else begin
                cmd_valid = 1'b0; cmd_code = 3'd7;
            end
            #1;
            if (!busy) break;
            nb++;
            if (tag_req_valid && tag_req_ready) begin
                hs_addr.push_back(tag_req_addr);
                hs_op.push_back(tag_req_op);
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0; cmd_code = 3'd7;
    endtask

    task automatic do_op(input logic [2:0] code, input logic [31:0] addr,
                         input bit inject, input bit full, input string req);
        logic [26:0] fl, ll;
        int nexp, expbusy, nb;
        logic [1:0] eop;
        bit experr;
        fl = addr[31:5]; ll = addr[31:5]; nexp = 0; expbusy = 0; eop = 2'd0;
        experr = err_m;
        case (code)
            3'd0, 3'd1, 3'd2: begin
                nexp = 1; eop = code[1:0] + 2'd1; experr = 0;
                expbusy = full ? 1 : -1;
            end
            3'd3, 3'd5: begin
                ms[code == 3'd5] = addr; experr = 0;
            end
            3'd4, 3'd6: begin
                fl = ms[code == 3'd6][31:5];
                eop = (code == 3'd4) ? 2'd1 : 2'd2;
                if (ms[code == 3'd6][31:12] != addr[31:12]) begin
                    experr = 1;
                end else if (ll < fl) begin
                    experr = 0; expbusy = 1;
                end else begin
                    experr = 0; nexp = int'(ll - fl) + 1;
                    expbusy = full ? nexp : -1;
                end
            end
            default: ;
        endcase
        err_m = experr;
        issue(code, addr);
        observe(inject, full, nb);
        check(hs_addr.size() == nexp, req, "line count", hs_addr.size(), nexp);
        for (int i = 0; i < hs_addr.size(); i++) begin
            if (hs_addr[i] != {fl + 27'(i), 5'b0} || hs_op[i] != eop) begin
                check(0, req, "line addr/op", {hs_op[i], hs_addr[i]},
                      {eop, fl + 27'(i), 5'b0});
                break;
            end
        end
        check(err == experr, req, "err flag", err, experr);
        if (expbusy >= 0)
            check(nb == expbusy, req, "busy cycles", nb, expbusy);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        ms[0] = '0; ms[1] = '0;
        tag_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R11 reset state
        check(!busy, "R11", "busy after reset", busy, 0);
        check(!tag_req_valid, "R11", "valid after reset", tag_req_valid, 0);
        check(!err, "R11", "err after reset", err, 0);
        // R11: clean start register is zero; R3 end write launches
        do_op(3'd4, 32'h0000_0040, 0, 1, "R11");
        // R1 R2 single-line ops
        do_op(3'd0, 32'h1234_5677, 0, 1, "R1");
        do_op(3'd1, 32'h1234_5680, 0, 0, "R2");
        do_op(3'd2, 32'h1234_569F, 0, 1, "R2");
        // R3 start writes alone stay idle; R8 overwrite and independence
        do_op(3'd3, 32'h1000_0100, 0, 1, "R3");
        do_op(3'd3, 32'h1000_0040, 0, 1, "R8");
        do_op(3'd5, 32'h1000_0800, 0, 1, "R8");
        do_op(3'd4, 32'h1000_00A0, 0, 1, "R8");
        // R4 range of one line at the start address
        do_op(3'd6, 32'h1000_0800, 0, 1, "R4");
        // R4 start and end inside one line
        do_op(3'd3, 32'h1000_0205, 0, 1, "R4");
        do_op(3'd4, 32'h1000_021F, 0, 0, "R4");
        // R6 page crossing refused, then cleared
        do_op(3'd5, 32'h1000_0FE0, 0, 1, "R6");
        do_op(3'd6, 32'h1000_1000, 0, 1, "R6");
        do_op(3'd0, 32'h1000_1000, 0, 1, "R6");
        // R7 reversed range
        do_op(3'd3, 32'h2000_0080, 0, 1, "R7");
        do_op(3'd4, 32'h2000_0060, 0, 1, "R7");
        // R5 long walk with full ready; R10 command injected mid-walk
        do_op(3'd3, 32'h3000_0000, 0, 1, "R5");
        do_op(3'd4, 32'h3000_0100, 1, 1, "R10");
        @(negedge clk); #1;
        check(!busy && !tag_req_valid, "R10", "idle after injected cmd",
              {busy, tag_req_valid}, 0);
        do_op(3'd7, 32'h3000_0000, 0, 1, "R10");
        // R9 stalled handshakes under random ready
        do_op(3'd5, 32'h4000_0000, 0, 0, "R9");
        do_op(3'd6, 32'h4000_03E0, 0, 0, "R9");
        // random mix
        for (int k = 0; k < 250; k++) begin
            logic [31:0] pg, s, e;
            int sel;
            pg  = 32'h8000_0000 | (($urandom % 4) << 12);
            s   = pg | ($urandom % 4096);
            sel = $urandom % 10;
            if (sel < 5)      e = s + ($urandom % 1024);
            else if (sel < 8) e = pg | ($urandom % 4096);
            else              e = (pg ^ 32'h0000_1000) | ($urandom % 4096);
            if ((k % 5) == 0) begin
                do_op(3'($urandom % 3), s, 0, 0, "R2");
            end else if ((k % 2) == 0) begin
                do_op(3'd3, s, 0, 0, "R3");
                do_op(3'd4, e, 0, 0, "R4");
            end else begin
                do_op(3'd5, s, 0, 0, "R3");
                do_op(3'd6, e, 0, 0, "R4");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule